// File: doc/BRIEF.md
# Atomic memory operation unit

This block carries out single-word atomic operations on behalf of a simple in-order core. The core hands it one operation at a time: a 5-bit operation code, a byte address taken from the first source register and an operand taken from the second. The unit then talks to memory through a word-wide request/ready port and reports back a value for the destination register, or an exception with its cause code.

Three families of operation are supported. A reserved load reads a word and sets a one-bit reservation. A conditional store writes only while that reservation is held. A read-modify-write operation reads the old word, combines it with the operand using one of nine functions, writes the result back and returns the old word. Misaligned addresses and unknown operation codes end at once with an exception and never reach memory.

The memory port is registered. A request is held unchanged until memory accepts it with ready. While an operation owns the port the unit shows busy and ignores new requests.

Top module: `amo_unit`

## Requirements
- R1: Valid operation codes are 00010 reserved load, 00011 conditional store, 00001 swap, 00000 add, 00100 xor, 01100 and, 01000 or, 10000 signed min, 10100 signed max, 11000 unsigned min and 11100 unsigned max. Any other code completes with exc_valid and cause 2, makes no memory request and leaves memory untouched. Cause 2 also wins when the address is misaligned.
- R2: An address with either of its two low bits set is misaligned. A reserved load then completes with cause 4, and a conditional store or read-modify-write with cause 6, with no memory request. Every request placed on the memory port is word aligned.
- R3: A reserved load makes one read and returns the word on rd_value. It also sets the reservation.
- R4: A conditional store issued while the reservation is set makes one write of the operand, returns 0 and clears the reservation, so that a second conditional store fails.
- R5: A conditional store issued without the reservation returns 1, makes no memory request, and raises done in the cycle after acceptance.
- R6: A read-modify-write makes exactly one read followed by exactly one write to the same word, and returns the original word.
- R7: The value written back is the operand for swap, and for the other functions it is old+operand, old^operand, old&operand, old|operand, or the signed or unsigned minimum or maximum of the old word and the operand.
- R8: Reset clears the reservation and leaves busy, done and mem_req low.
- R9: busy is high from the cycle after a memory operation is accepted until its final handshake. Requests offered meanwhile are ignored. A memory request holds its address, direction and data until ready is seen.
- R10: done is high for one cycle per operation, with busy low. exc_valid can only be high together with done. A request offered in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation offered; taken when busy is low |
| req_op | input | 5 | Operation code (see R1) |
| req_addr | input | ADDR_W | Byte address of the word |
| req_operand | input | DATA_W | Operand value |
| busy | output | 1 | Memory phase in progress |
| done | output | 1 | Completion pulse |
| exc_valid | output | 1 | Completion is an exception |
| exc_cause | output | CAUSE_W | Exception cause code |
| rd_value | output | DATA_W | Destination register value |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Write data |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DATA_W | Read data, valid with mem_ready on a read |

## Verification
Two events can land in the same cycle: the done pulse that closes one operation, and the acceptance of the next request. The bench provokes this by offering the next operation in the same cycle it sees done. Typical pairs are a reserved load followed straight away by a conditional store, which must then see the reservation just set, and a failed conditional store followed by another request. Memory answers after a random delay. Each result, handshake count and memory word is compared with a model in the bench, and that model advances only when done is seen.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OPC_ADD  = 5'b00000;
  localparam logic [OP_W-1:0] OPC_SWAP = 5'b00001;
  localparam logic [OP_W-1:0] OPC_LR   = 5'b00010;
  localparam logic [OP_W-1:0] OPC_SC   = 5'b00011;
  localparam logic [OP_W-1:0] OPC_XOR  = 5'b00100;
  localparam logic [OP_W-1:0] OPC_OR   = 5'b01000;
  localparam logic [OP_W-1:0] OPC_AND  = 5'b01100;
  localparam logic [OP_W-1:0] OPC_MIN  = 5'b10000;
  localparam logic [OP_W-1:0] OPC_MAX  = 5'b10100;
  localparam logic [OP_W-1:0] OPC_MINU = 5'b11000;
  localparam logic [OP_W-1:0] OPC_MAXU = 5'b11100;

  localparam int unsigned CAUSE_ILLEGAL = 2;
  localparam int unsigned CAUSE_LD_MIS  = 4;
  localparam int unsigned CAUSE_ST_MIS  = 6;

  typedef enum logic [1:0] {K_BAD, K_LR, K_SC, K_RMW} amo_kind_e;

  typedef enum logic [3:0] {
    FN_SWAP, FN_ADD, FN_XOR, FN_AND, FN_OR,
    FN_MIN, FN_MAX, FN_MINU, FN_MAXU
  } amo_fn_e;

  typedef enum logic [1:0] {S_IDLE, S_READ, S_WRITE} amo_state_e;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  logic [OP_W-1:0]  op,
  input  logic [OFF_W-1:0] addr_lo,
  output amo_kind_e        kind,
  output amo_fn_e          fn,
  output logic             misaligned
);
  always_comb begin
    kind = K_BAD;
    fn   = FN_SWAP;
    case (op)
      OPC_LR:   kind = K_LR;
      OPC_SC:   kind = K_SC;
      OPC_SWAP: begin kind = K_RMW; fn = FN_SWAP; end
      OPC_ADD:  begin kind = K_RMW; fn = FN_ADD;  end
      OPC_XOR:  begin kind = K_RMW; fn = FN_XOR;  end
      OPC_AND:  begin kind = K_RMW; fn = FN_AND;  end
      OPC_OR:   begin kind = K_RMW; fn = FN_OR;   end
      OPC_MIN:  begin kind = K_RMW; fn = FN_MIN;  end
      OPC_MAX:  begin kind = K_RMW; fn = FN_MAX;  end
      OPC_MINU: begin kind = K_RMW; fn = FN_MINU; end
      OPC_MAXU: begin kind = K_RMW; fn = FN_MAXU; end
      default:  kind = K_BAD;
    endcase
  end

  assign misaligned = |addr_lo;
endmodule

// File: rtl/amo_combine.sv
module amo_combine
  import amo_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  amo_fn_e           fn,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result
);
  logic lt_s;
  logic lt_u;

  assign lt_s = $signed(old_word) < $signed(operand);
  assign lt_u = old_word < operand;

  always_comb begin
    case (fn)
      FN_SWAP: result = operand;
      FN_ADD:  result = old_word + operand;
      FN_XOR:  result = old_word ^ operand;
      FN_AND:  result = old_word & operand;
      FN_OR:   result = old_word | operand;
      FN_MIN:  result = lt_s ? old_word : operand;
      FN_MAX:  result = lt_s ? operand  : old_word;
      FN_MINU: result = lt_u ? old_word : operand;
      FN_MAXU: result = lt_u ? operand  : old_word;
      default: result = operand;
    endcase
  end
endmodule

// File: rtl/amo_resv.sv
module amo_resv (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic held
);
  always_ff @(posedge clk) begin
    if (rst)        held <= 1'b0;
    else if (set_i) held <= 1'b1;
    else if (clr_i) held <= 1'b0;
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [OP_W-1:0]     req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_operand,
  output logic                busy,
  output logic                done,
  output logic                exc_valid,
  output logic [CAUSE_W-1:0]  exc_cause,
  output logic [DATA_W-1:0]   rd_value,
  output logic                mem_req,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  input  logic                mem_ready,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  amo_state_e        state_q;
  amo_kind_e         kind_q;
  amo_fn_e           fn_q;
  logic [DATA_W-1:0] opd_q;
  logic [DATA_W-1:0] old_q;

  amo_kind_e         dec_kind;
  amo_fn_e           dec_fn;
  logic              dec_mis;
  logic [DATA_W-1:0] comb_result;
  logic              resv_held;
  logic              resv_set;
  logic              resv_clr;

  amo_decode #(.OFF_W(OFF_W)) dec_i (
    .op         (req_op),
    .addr_lo    (req_addr[OFF_W-1:0]),
    .kind       (dec_kind),
    .fn         (dec_fn),
    .misaligned (dec_mis)
  );

  amo_combine #(.DATA_W(DATA_W)) alu_i (
    .fn       (fn_q),
    .old_word (mem_rdata),
    .operand  (opd_q),
    .result   (comb_result)
  );

  assign resv_set = (state_q == S_READ)  && mem_ready && (kind_q == K_LR);
  assign resv_clr = (state_q == S_WRITE) && mem_ready && (kind_q == K_SC);

  amo_resv resv_i (
    .clk   (clk),
    .rst   (rst),
    .set_i (resv_set),
    .clr_i (resv_clr),
    .held  (resv_held)
  );

  assign busy = (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      kind_q    <= K_BAD;
      fn_q      <= FN_SWAP;
      opd_q     <= '0;
      old_q     <= '0;
      done      <= 1'b0;
      exc_valid <= 1'b0;
      exc_cause <= '0;
      rd_value  <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done      <= 1'b0;
      exc_valid <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (req_valid) begin
            kind_q   <= dec_kind;
            fn_q     <= dec_fn;
            opd_q    <= req_operand;
            mem_addr <= req_addr;
            if (dec_kind == K_BAD) begin
              done      <= 1'b1;
              exc_valid <= 1'b1;
              exc_cause <= CAUSE_W'(CAUSE_ILLEGAL);
              rd_value  <= '0;
            end else if (dec_mis) begin
              done      <= 1'b1;
              exc_valid <= 1'b1;
              exc_cause <= (dec_kind == K_LR) ? CAUSE_W'(CAUSE_LD_MIS)
                                              : CAUSE_W'(CAUSE_ST_MIS);
              rd_value  <= '0;
            end else begin
              case (dec_kind)
                K_SC: begin
                  if (resv_held) begin
                    state_q   <= S_WRITE;
                    mem_req   <= 1'b1;
                    mem_we    <= 1'b1;
                    mem_wdata <= req_operand;
                  end else begin
                    done     <= 1'b1;
                    rd_value <= DATA_W'(1);
                  end
                end
                default: begin
                  state_q <= S_READ;
                  mem_req <= 1'b1;
                  mem_we  <= 1'b0;
                end
              endcase
            end
          end
        end
        S_READ: begin
          if (mem_ready) begin
            if (kind_q == K_LR) begin
              state_q  <= S_IDLE;
              mem_req  <= 1'b0;
              done     <= 1'b1;
              rd_value <= mem_rdata;
            end else begin
              state_q   <= S_WRITE;
              old_q     <= mem_rdata;
              mem_we    <= 1'b1;
              mem_wdata <= comb_result;
            end
          end
        end
        S_WRITE: begin
          if (mem_ready) begin
            state_q  <= S_IDLE;
            mem_req  <= 1'b0;
            mem_we   <= 1'b0;
            done     <= 1'b1;
            rd_value <= (kind_q == K_SC) ? '0 : old_q;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic               done,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic               mem_req,
  input logic               mem_we,
  input logic [ADDR_W-1:0]  mem_addr,
  input logic [DATA_W-1:0]  mem_wdata,
  input logic               mem_ready
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
  AST_ALIGNED_ACCESS: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R10
  AST_EXC_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> done); // R10
  AST_EXC_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> !$past(mem_req)); // R1
  AST_EXC_CAUSE_KNOWN: assert property (@(posedge clk) disable iff (rst)
    exc_valid |-> (exc_cause == CAUSE_W'(2) || exc_cause == CAUSE_W'(4) || exc_cause == CAUSE_W'(6))); // R2
endmodule

bind amo_unit amo_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CAUSE_W(CAUSE_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .exc_valid (exc_valid),
  .exc_cause (exc_cause),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready)
);

// File: tb/amo_unit_tb_top.sv
`timescale 1ns/1ps
module amo_unit_tb_top;
  import amo_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [4:0]  req_op = '0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_operand = '0;
  logic        busy, done, exc_valid;
  logic [3:0]  exc_cause;
  logic [31:0] rd_value;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_cmp = 0;
  int n_bad = 0;
  int n_hs  = 0;
  logic [31:0] bmem [16];
  bit resv_m = 1'b0;

  always #10 clk = ~clk;

  amo_unit dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_operand(req_operand), .busy(busy), .done(done),
    .exc_valid(exc_valid), .exc_cause(exc_cause), .rd_value(rd_value),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // memory model: decides ready for the coming edge, applies writes
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && mem_req && ($urandom % 4) != 0) begin
        mem_ready = 1'b1;
        n_hs++;
        if (mem_we) bmem[mem_addr[5:2]] = mem_wdata;
        else        mem_rdata = bmem[mem_addr[5:2]];
      end else begin
        mem_ready = 1'b0;
        mem_rdata = $urandom;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    summary();
    $finish;
  end

  function automatic int kind_of(input logic [4:0] op);
    case (op)
      OPC_LR: return 1;
      OPC_SC: return 2;
      OPC_SWAP, OPC_ADD, OPC_XOR, OPC_AND, OPC_OR,
      OPC_MIN, OPC_MAX, OPC_MINU, OPC_MAXU: return 3;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] ref_comb(input logic [4:0] op,
                                           input logic [31:0] o, input logic [31:0] v);
    case (op)
      OPC_SWAP: return v;
      OPC_ADD:  return o + v;
      OPC_XOR:  return o ^ v;
      OPC_AND:  return o & v;
      OPC_OR:   return o | v;
      OPC_MIN:  return ($signed(o) < $signed(v)) ? o : v;
      OPC_MAX:  return ($signed(o) > $signed(v)) ? o : v;
      OPC_MINU: return (o < v) ? o : v;
      OPC_MAXU: return (o > v) ? o : v;
      default:  return v;
    endcase
  endfunction

  // called at a negedge; returns at the negedge where done is seen
  task automatic run_op(input logic [4:0] op, input logic [31:0] addr,
                        input logic [31:0] opd, input bit inject);
    int k = kind_of(op);
    int idx = int'(addr[5:2]);
    logic [31:0] old = bmem[idx];
    bit mis = (addr[1:0] != 2'b00);
    bit e_exc = 1'b0;
    int e_cause = 0;
    logic [31:0] e_rd = '0;
    int e_hs = 0;
    logic [31:0] e_mem = old;
    string tag;
    int hs0 = n_hs;
    int lat = 0;
    bit got = 1'b0;
    if (k == 0) begin e_exc = 1; e_cause = 2; tag = "R1"; end
    else if (mis) begin e_exc = 1; e_cause = (k == 1) ? 4 : 6; tag = "R2"; end
    else if (k == 1) begin e_rd = old; e_hs = 1; tag = "R3"; end
    else if (k == 2 && resv_m) begin e_rd = 0; e_hs = 1; e_mem = opd; tag = "R4"; end
    else if (k == 2) begin e_rd = 1; tag = "R5"; end
    else begin e_rd = old; e_hs = 2; e_mem = ref_comb(op, old, opd); tag = "R7"; end
    req_valid = 1'b1; req_op = op; req_addr = addr; req_operand = opd;
    while (!got) begin
      @(negedge clk);
      lat++;
      if (done) got = 1'b1;
      else begin
        chk(busy, "R9", "busy while in flight", 32'(busy), 32'd1);
        if (inject && busy) begin
          req_valid = 1'b1; req_op = 5'b11111; req_addr = $urandom % 64;
          req_operand = $urandom;
        end else req_valid = 1'b0;
        if (lat > 60) begin
          chk(1'b0, "R10", "no done", 32'(lat), 32'd60);
          got = 1'b1;
        end
      end
    end
    req_valid = 1'b0;
    chk(exc_valid == e_exc, tag, "exc_valid", 32'(exc_valid), 32'(e_exc));
    if (e_exc) chk(exc_cause == 4'(e_cause), tag, "cause", 32'(exc_cause), 32'(e_cause));
    else       chk(rd_value == e_rd, tag, "rd_value", rd_value, e_rd);
    chk(n_hs - hs0 == e_hs, (k == 3 && !e_exc) ? "R6" : tag, "handshakes",
        32'(n_hs - hs0), 32'(e_hs));
    chk(bmem[idx] == e_mem, tag, "memory word", bmem[idx], e_mem);
    chk(!busy, "R10", "busy with done", 32'(busy), 32'd0);
    if (tag == "R5") chk(lat == 1, "R5", "failed store latency", 32'(lat), 32'd1);
    if (!e_exc && k == 1) resv_m = 1'b1;
    if (!e_exc && k == 2) resv_m = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R8", "reset outputs",
        {29'd0, busy, done, mem_req}, 32'd0);
    rst = 1'b0;
    resv_m = 1'b0;
  endtask

  function automatic logic [4:0] pick_op(input int i);
    case (i)
      0, 1, 2: return OPC_LR;
      3, 4:    return OPC_SC;
      5:       return OPC_SWAP;
      6:       return OPC_ADD;
      7:       return OPC_XOR;
      8:       return OPC_AND;
      9:       return OPC_OR;
      10:      return OPC_MIN;
      11:      return OPC_MAX;
      12:      return OPC_MINU;
      13:      return OPC_MAXU;
      default: return 5'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 16; i++) bmem[i] = $urandom;
    bmem[2] = 32'h8000_0000;
    bmem[3] = 32'h7fff_ffff;
    do_reset();
    // R8: no reservation after reset
    run_op(OPC_SC, 32'd8, 32'h1111_1111, 0);
    // R3 then R4 back to back, then a second store must fail
    run_op(OPC_LR, 32'd8, 32'h0, 0);
    run_op(OPC_SC, 32'd8, 32'hcafe_f00d, 0);
    run_op(OPC_SC, 32'd8, 32'h2222_2222, 0);
    // R7 corner values on signed / unsigned comparisons
    run_op(OPC_MIN,  32'd8,  32'h0000_0001, 0);
    run_op(OPC_MAX,  32'd12, 32'h8000_0000, 0);
    run_op(OPC_MINU, 32'd12, 32'hffff_ffff, 0);
    run_op(OPC_MAXU, 32'd8,  32'hffff_ffff, 1);
    run_op(OPC_ADD,  32'd12, 32'h0000_0001, 1);
    run_op(OPC_SWAP, 32'd16, 32'h1234_5678, 0);
    run_op(OPC_XOR,  32'd16, 32'hffff_0000, 0);
    run_op(OPC_AND,  32'd16, 32'h0f0f_0f0f, 0);
    run_op(OPC_OR,   32'd16, 32'h3000_0003, 0);
    // R2 misalignment per kind, R1 unknown codes
    run_op(OPC_LR,   32'd5, 32'h0, 0);
    run_op(OPC_SC,   32'd6, 32'h0, 0);
    run_op(OPC_ADD,  32'd3, 32'h0, 0);
    run_op(5'b00101, 32'd4, 32'h0, 0);
    run_op(5'b11111, 32'd7, 32'h0, 0);
    // R8: reset drops a held reservation
    run_op(OPC_LR, 32'd20, 32'h0, 0);
    do_reset();
    run_op(OPC_SC, 32'd20, 32'h5555_5555, 0);
    // random mix with back-to-back issue and ignored requests (R9, R10)
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a = $urandom % 64;
      logic [31:0] v;
      if (($urandom % 5) != 0) a[1:0] = 2'b00;
      case ($urandom % 4)
        0: v = 32'h8000_0000;
        1: v = 32'hffff_ffff;
        default: v = $urandom;
      endcase
      if (($urandom % 3) == 0) @(negedge clk);
      run_op(pick_op($urandom % 16), a, v, ($urandom % 2) == 1);
    end
    summary();
    $finish;
  end
endmodule